// File: doc/BRIEF.md
# Pipelined Burst SRAM with Zero-Turnaround Interface

A clocked single-port memory whose interface registers every control and address input on the rising edge and keeps a fixed two-cycle distance between an address cycle and its data. A read returns its word two enabled clocks after the address edge. A write takes its data two enabled clocks after the address edge. Because both directions sit at the same distance, reads and writes can be interleaved on every cycle with no idle slot between them. Separate input and output data buses are used. An active-low output enable gates the output side without touching the pipeline.

A load cycle brings in an external address, a direction and the three chip selects. The following advance cycles step a two-bit burst counter seeded from the loaded address. The counter walks in linear order and wraps within a group of four words. Per-lane write masks travel with the address and are applied to the data that arrives two cycles later. An active-low clock enable stalls the whole block, so several devices can share a bus or be paused together.

Top module: `nbt_burst_sram`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, rvalid is low and no operation is in flight.
- R2: An operation issued on enabled edge N is completed on enabled edge N+2. A read's word is on rdata with rvalid high from that edge on. A write stores wdata as sampled at that edge. Reads and writes may be issued on consecutive edges with results in program order.
- R3: load_n low loads addr. Each edge with load_n high uses the previously issued address with its two low bits incremented modulo 4, and the upper bits unchanged.
- R4: During advance edges (load_n high), we_n is ignored. The burst keeps the direction set on its load edge (we_n low = write, high = read).
- R5: A load edge selects the device only if sel1_n=0, sel2_n=0 and sel3=1. A deselected load, and every advance that follows it, is a bubble: nothing is written and rvalid is low in its read slot.
- R6: byte_we_n is sampled on the address edge. Bit i low enables writing lane i, which is wdata[9*i+8:9*i], with lane 0 in the lowest bits. Lanes whose bit is high keep their old contents.
- R7: While clk_en_n is high, an edge changes nothing. No write happens, rdata and rvalid hold, and the burst position holds.
- R8: oe_n is asynchronous and active low. While it is high, rvalid is 0 and rdata is all zeros. It has no effect on the pipeline or the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high stalls every register |
| load_n | input | 1 | Low: load a new address; high: advance the burst |
| we_n | input | 1 | Direction on load edges: low write, high read |
| sel1_n | input | 1 | Active-low chip select, sampled on load edges |
| sel2_n | input | 1 | Active-low chip select, sampled on load edges |
| sel3 | input | 1 | Active-high chip select, sampled on load edges |
| addr | input | ADDR_W | Word address, sampled on load edges |
| byte_we_n | input | LANES | Active-low per-lane write mask, sampled with the address |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Read data, zero while oe_n is high |
| rvalid | output | 1 | High while rdata holds a read result and oe_n is low |

## Verification
A wrong burst position or a wrong stored direction does not show when the address is taken. It first shows two enabled edges later. A misplaced write then surfaces only on a later read of the affected word, when rdata differs from the value the reference expects. A pipeline that loses or adds a stage, or that keeps moving during a stall, shows in the very next compare as rvalid in the wrong slot. The bench reloads the whole memory before the scenarios start, and it reads back every word it writes soon afterwards. Each corrupted lane therefore reaches the ports within a few dozen cycles.

// File: rtl/nbt_burst_sram.sv
module nbt_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en_n,
  input  logic                      load_n,
  input  logic                      we_n,
  input  logic                      sel1_n,
  input  logic                      sel2_n,
  input  logic                      sel3,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          byte_we_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      oe_n,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rvalid
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              s1_v, s1_w, s2_v, s2_w, rv_q;
  logic [ADDR_W-1:0] s1_a, s2_a, nxt_a;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [DATA_W-1:0] rd_word;
  logic              nxt_v, nxt_w, chip_on, run;

  assign run     = ~clk_en_n;
  assign chip_on = ~sel1_n & ~sel2_n & sel3;
  assign nxt_a   = load_n ? {s1_a[ADDR_W-1:2], s1_a[1:0] + 2'd1} : addr;
  assign nxt_v   = load_n ? s1_v : chip_on;
  assign nxt_w   = load_n ? s1_w : ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_w  <= 1'b0;
      s1_a  <= '0;
      s1_be <= '1;
      s2_v  <= 1'b0;
      s2_w  <= 1'b0;
      s2_a  <= '0;
      s2_be <= '1;
      rv_q  <= 1'b0;
    end else if (run) begin
      s1_v  <= nxt_v;
      s1_w  <= nxt_w;
      s1_a  <= nxt_a;
      s1_be <= byte_we_n;
      s2_v  <= s1_v;
      s2_w  <= s1_w;
      s2_a  <= s1_a;
      s2_be <= s1_be;
      rv_q  <= s2_v & ~s2_w;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (run && s2_v) begin
        if (s2_w && !s2_be[g]) ram[s2_a] <= wdata[g*LANE_W +: LANE_W];
        if (!s2_w) q <= ram[s2_a];
      end
    end
    assign rd_word[g*LANE_W +: LANE_W] = q;
  end

  assign rvalid = rv_q & ~oe_n;
  assign rdata  = oe_n ? '0 : rd_word;
endmodule

module nbt_burst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              load_n,
  input logic              oe_n,
  input logic              sel1_n,
  input logic              sel2_n,
  input logic              sel3,
  input logic              s1_v,
  input logic              s1_w,
  input logic [ADDR_W-1:0] s1_a,
  input logic              s2_v,
  input logic              s2_w,
  input logic              rv_q,
  input logic              rvalid
);
  a_r7_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(rv_q) && $stable(s1_a) && $stable(s2_v) && $stable(s1_v));

  a_r8_oe_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rvalid);

  a_r5_deselect_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && !(!sel1_n && !sel2_n && sel3)) |=> !s1_v);

  a_r2_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_v && !s2_w) |=> rv_q);

  a_r3_linear_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && s1_v) |=>
      (s1_a[1:0] == $past(s1_a[1:0]) + 2'd1) && (s1_a[ADDR_W-1:2] == $past(s1_a[ADDR_W-1:2])));

  a_r4_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && s1_v) |=> s1_w == $past(s1_w));
endmodule

bind nbt_burst_sram nbt_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n), .oe_n(oe_n),
  .sel1_n(sel1_n), .sel2_n(sel2_n), .sel3(sel3), .s1_v(s1_v), .s1_w(s1_w),
  .s1_a(s1_a), .s2_v(s2_v), .s2_w(s2_w), .rv_q(rv_q), .rvalid(rvalid)
);

// File: tb/nbt_burst_sram_tb.sv
module nbt_burst_sram_tb;
  logic        clk = 0, rst_n = 0, clk_en_n = 0, load_n = 0, we_n = 1;
  logic        sel1_n = 0, sel2_n = 0, sel3 = 0, oe_n = 0;
  logic [7:0]  addr = 0;
  logic [3:0]  byte_we_n = 4'hF;
  logic [35:0] wdata = 0;
  logic [35:0] rdata;
  logic        rvalid;

  nbt_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n), .we_n(we_n),
    .sel1_n(sel1_n), .sel2_n(sel2_n), .sel3(sel3), .addr(addr), .byte_we_n(byte_we_n),
    .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  always #10 clk = ~clk;

  typedef struct { bit v; bit w; bit [7:0] a; bit [3:0] be; } op_t;
  op_t         pend[$];
  bit   [35:0] ref_mem [256];
  bit          last_v, last_w, exp_v, done;
  bit   [7:0]  last_a;
  bit   [35:0] exp_q;
  int          checks = 0, failures = 0;
  string       ph = "R1";

  task automatic chk(input bit ok, input string what, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got %h exp %h", ph, what, got, exp);
    end
  endtask

  task automatic compare();
    bit erv;
    erv = exp_v && !oe_n;
    chk(rvalid === erv, "rvalid", {35'd0, rvalid}, {35'd0, erv});
    if (erv) chk(rdata === exp_q, "rdata", rdata, exp_q);
    if (oe_n) chk(rdata === 36'd0, "rdata gated", rdata, 36'd0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pend.delete();
      pend.push_back('{v:0, w:0, a:0, be:4'hF});
      pend.push_back('{v:0, w:0, a:0, be:4'hF});
      exp_v = 0; last_v = 0; last_w = 0; last_a = 0;
    end else if (!clk_en_n) begin
      op_t n, f;
      if (!load_n) begin
        n.v = !sel1_n && !sel2_n && sel3; n.w = !we_n; n.a = addr;
      end else begin
        n.v = last_v; n.w = last_w; n.a = {last_a[7:2], 2'(last_a[1:0] + 2'd1)};
      end
      n.be = byte_we_n;
      last_v = n.v; last_w = n.w; last_a = n.a;
      pend.push_back(n);
      f = pend.pop_front();
      if (f.v && f.w)
        for (int i = 0; i < 4; i++)
          if (!f.be[i]) ref_mem[f.a][i*9 +: 9] = wdata[i*9 +: 9];
      exp_v = f.v && !f.w;
      if (exp_v) exp_q = ref_mem[f.a];
    end
    #5 compare();
  end

  task automatic step(input bit ld_n, input bit w_n, input bit [7:0] a, input bit [3:0] be);
    load_n = ld_n; we_n = w_n; addr = a; byte_we_n = be;
    wdata = {$urandom, $urandom};
    @(negedge clk);
  endtask

  task automatic idle();
    sel3 = 0; step(0, 1, 8'h00, 4'hF); sel3 = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired in %s", ph);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; sel3 = 1;
    @(negedge clk);
    ph = "R6";
    for (int a = 0; a < 256; a++) step(0, 0, 8'(a), 4'h0);
    ph = "R2";
    for (int i = 0; i < 16; i++) begin
      step(0, 1, 8'(3 * i), 4'hF);
      step(0, 0, 8'(100 + i), 4'h0);
      step(0, 1, 8'(100 + i), 4'hF);
    end
    ph = "R3";
    step(0, 1, 8'h41, 4'hF); step(1, 1, 0, 4'hF); step(1, 1, 0, 4'hF); step(1, 1, 0, 4'hF);
    step(0, 0, 8'h86, 4'h0); step(1, 0, 0, 4'h0); step(1, 0, 0, 4'h0); step(1, 0, 0, 4'h0);
    step(0, 1, 8'h84, 4'hF); step(1, 1, 0, 4'hF); step(1, 1, 0, 4'hF); step(1, 1, 0, 4'hF);
    ph = "R4";
    step(0, 0, 8'h22, 4'h0); step(1, 1, 0, 4'h0); step(1, 1, 0, 4'h0); step(1, 0, 0, 4'h0);
    step(0, 1, 8'h20, 4'hF); step(1, 0, 0, 4'h0); step(1, 0, 0, 4'h0); step(1, 0, 0, 4'h0);
    ph = "R5";
    sel1_n = 1; step(0, 0, 8'h30, 4'h0); step(1, 0, 0, 4'h0); sel1_n = 0;
    sel2_n = 1; step(0, 0, 8'h31, 4'h0); sel2_n = 0;
    sel3 = 0;   step(0, 0, 8'h32, 4'h0); step(0, 1, 8'h33, 4'hF); step(1, 1, 0, 4'hF); sel3 = 1;
    for (int a = 8'h30; a < 8'h34; a++) step(0, 1, 8'(a), 4'hF);
    idle(); idle();
    ph = "R6";
    step(0, 0, 8'h50, 4'b1110); step(0, 0, 8'h51, 4'b0101);
    step(0, 0, 8'h52, 4'b1111); step(0, 0, 8'h53, 4'b0111);
    for (int a = 8'h50; a < 8'h54; a++) step(0, 1, 8'(a), 4'hF);
    idle(); idle();
    ph = "R7";
    step(0, 0, 8'h60, 4'h0); step(0, 1, 8'h60, 4'hF);
    clk_en_n = 1; step(0, 0, 8'h61, 4'h0); step(0, 0, 8'h62, 4'h0); step(1, 1, 0, 4'h0); clk_en_n = 0;
    step(0, 1, 8'h61, 4'hF);
    clk_en_n = 1; step(0, 1, 8'h62, 4'hF); step(0, 1, 8'h63, 4'hF); clk_en_n = 0;
    idle(); idle(); idle();
    ph = "R8";
    step(0, 1, 8'h10, 4'hF); step(0, 1, 8'h11, 4'hF);
    oe_n = 1; step(0, 1, 8'h12, 4'hF); #1 compare();
    oe_n = 0; #1 compare();
    step(0, 1, 8'h13, 4'hF);
    oe_n = 1; step(1, 1, 0, 4'hF); oe_n = 0; step(1, 1, 0, 4'hF);
    idle(); idle(); idle();
    ph = "R1";
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    idle(); idle();
    finish_run();
  end
endmodule